// File: doc/BRIEF.md
# Serial Channel Control Port

This block is the processor-facing register front end of one asynchronous serial channel. The processor sees two locations: a data location and a control location. The serial shifters and the baud logic sit outside this block. It drives their enable and format settings and takes their status flags back. A write to the data location hands a byte to the transmitter. A read of the data location returns the last received character.

Writes to the control location and reads of the status byte share one address. They are steered by a small register pointer. When the pointer is zero, a control write loads a new pointer value into bits 2:0 and may carry a command code in bits 5:3. Any control access while the pointer is nonzero reaches the selected register, and the pointer then falls back to zero by itself. So firmware can always recover a known state by writing 0x00 and then reading status.

The status byte is built each cycle from live line inputs and from two pieces of internal state: the receive-available flag and the interrupt-pending term. A second readable register holds the sticky receive error flags. An error-reset command clears those flags. A channel-reset command returns everything to its reset state.

Top module: `sio_ctl_port`

## Requirements
- R1: After synchronous reset, every configuration output, `tx_load` and `int_pend` is 0, the pointer is 0, and a control read returns the status byte with bit 0 clear.
- R2: With the pointer at 0, a control write loads bits 2:0 into the pointer. The next control access (read or write) reaches that register, and the pointer is 0 again in the cycle after that access. Writing 0x00 makes the next control read return status.
- R3: A control write at pointer 0 with bits 5:3 = 011 (for example 0x18) clears registers 1, 3, 4 and 5, the pointer, the latched error flags and the receive-available flag, whatever the value of bits 2:0.
- R4: A control write at pointer 0 with bits 5:3 = 110 (for example 0x30) clears the three latched error flags. The write registers are left unchanged.
- R5: Register 1 holds the interrupt enables: bit 0 `ext_ie`, bit 1 `tx_ie`, bits 4:3 `rx_int_mode`. Writing 0x00 disables all of them.
- R6: Register 3 drives bits 7:6 `rx_bits` (11 = 8 bits), bit 5 `auto_enable` and bit 0 `rx_enable`. 0xC1 gives 8 bits, no auto enables, and the receiver on.
- R7: Register 4 drives bits 7:6 `clk_mode` (01 = x16), bits 3:2 `stop_sel` (01 = one stop bit), bit 1 `parity_even` and bit 0 `parity_en`. 0x44 gives x16, one stop bit, no parity.
- R8: Register 5 drives bit 7 `dtr`, bits 6:5 `tx_bits`, bit 4 `send_break`, bit 3 `tx_enable` and bit 1 `rts`. 0x68 gives 8 bits, the transmitter on, and `dtr`/`rts` low. Writes to registers 2, 6 and 7 change no output.
- R9: A control read at pointer 0 returns, in the same cycle, {bit 7 break, bit 6 = 0, bit 5 CTS, bit 4 RI, bit 3 DCD, bit 2 transmit empty, bit 1 interrupt pending (0 when the channel is not channel A), bit 0 receive available}.
- R10: `rx_strobe` sets receive-available and captures `rx_char` only while `rx_enable` is 1. Otherwise it is ignored. A data read returns the captured character and clears receive-available. A strobe in the same cycle wins.
- R11: A control read at pointer 1 returns {0, framing, overrun, parity, 0000}. Reads at pointers 2 to 7 return 0. Framing and parity flags latch from the strobe inputs. Overrun latches when a character is accepted while receive-available is still set and no data read occurs in that cycle.
- R12: A data write raises `tx_load` in the same cycle, with `tx_data` equal to the written byte, only when `tx_enable` is 1.
- R13: The interrupt-pending term is high when any of these holds: `rx_int_mode` is nonzero and receive-available is set; `tx_ie` and `tx_empty` are both set; `ext_ie` and `rx_break` are both set. It appears on `int_pend` and in status bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_ctl | input | 1 | 1 selects the control location, 0 the data location |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| rx_strobe | input | 1 | Receiver delivers a character |
| rx_char | input | 8 | Delivered character |
| rx_frm_err | input | 1 | Framing error for the delivered character |
| rx_par_err | input | 1 | Parity error for the delivered character |
| rx_break | input | 1 | Line break detected (live) |
| tx_empty | input | 1 | Transmit buffer empty (live) |
| cts | input | 1 | Clear-to-send line (live) |
| ri | input | 1 | Ring indicator line (live) |
| dcd | input | 1 | Carrier detect line (live) |
| rx_enable | output | 1 | Receiver enable |
| rx_bits | output | 2 | Receive character length code |
| auto_enable | output | 1 | Automatic handshake enables |
| clk_mode | output | 2 | Clock divide code |
| stop_sel | output | 2 | Stop bit code |
| parity_en | output | 1 | Parity enable |
| parity_even | output | 1 | Even parity select |
| tx_enable | output | 1 | Transmitter enable |
| tx_bits | output | 2 | Transmit character length code |
| send_break | output | 1 | Force break on line |
| dtr | output | 1 | DTR asserted |
| rts | output | 1 | RTS asserted |
| ext_ie | output | 1 | Line-status interrupt enable |
| tx_ie | output | 1 | Transmit interrupt enable |
| rx_int_mode | output | 2 | Receive interrupt mode |
| tx_load | output | 1 | Load `tx_data` into the transmitter |
| tx_data | output | 8 | Byte for the transmitter |
| int_pend | output | 1 | Interrupt pending |

## Verification
Some rules are checked by the bound properties on every cycle:
- the pointer falls back to zero after an access to a nonzero register;
- the channel-reset and error-reset commands clear their targets one cycle later;
- status bit 6 reads 0, and the CTS and receive-available bits reach the read path;
- `tx_load` is never raised without a transmitter enable;
- a data read clears receive-available, and an accepted strobe sets it.

Other behaviour can only be shown by the bench's scenarios, because it depends on the history of writes. That covers the field placement in registers 1, 3, 4 and 5, the error-register layout, when overrun latches, and whether the interrupt term is correct. The bench compares these against a reference model across random pointer, command and receive sequences.

// File: rtl/sio_pkg.sv
package sio_pkg;

    localparam int BYTE_W   = 8;
    localparam int PTR_W    = 3;
    localparam int NUM_REGS = 1 << PTR_W;
    localparam int CMD_LSB  = PTR_W;
    localparam int CMD_W    = 3;
    localparam int CMD_MSB  = CMD_LSB + CMD_W - 1;

    typedef enum logic [CMD_W-1:0] {
        CMD_NOP      = 3'b000,
        CMD_CHAN_RST = 3'b011,
        CMD_ERR_RST  = 3'b110
    } cmd_e;

    // register 1: interrupt enables
    typedef struct packed {
        logic [2:0] rsvd_hi;
        logic [1:0] rx_mode;
        logic       rsvd_lo;
        logic       tx_ie;
        logic       ext_ie;
    } ie_reg_t;

    // register 3: receiver setup
    typedef struct packed {
        logic [1:0] rx_bits;
        logic       auto_en;
        logic [3:0] rsvd;
        logic       rx_en;
    } rxc_reg_t;

    // register 4: clocking and framing
    typedef struct packed {
        logic [1:0] clk_mode;
        logic [1:0] rsvd;
        logic [1:0] stop_sel;
        logic       par_even;
        logic       par_en;
    } fmt_reg_t;

    // register 5: transmitter and modem control
    typedef struct packed {
        logic       dtr;
        logic [1:0] tx_bits;
        logic       brk;
        logic       tx_en;
        logic       rsvd_hi;
        logic       rts;
        logic       rsvd_lo;
    } txc_reg_t;

    typedef struct packed {
        logic frm;
        logic ovr;
        logic par;
    } rx_err_t;

    typedef struct packed {
        logic brk;
        logic cts;
        logic ri;
        logic dcd;
        logic txe;
    } line_t;

    function automatic cmd_e decode_cmd(input logic [CMD_W-1:0] code);
        case (code)
            3'b011:  return CMD_CHAN_RST;
            3'b110:  return CMD_ERR_RST;
            default: return CMD_NOP;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] build_status(input line_t ln,
                                                       input logic intp,
                                                       input logic avail);
        return {ln.brk, 1'b0, ln.cts, ln.ri, ln.dcd, ln.txe, intp, avail};
    endfunction

    function automatic logic [BYTE_W-1:0] build_err(input rx_err_t e);
        return {1'b0, e.frm, e.ovr, e.par, 4'b0000};
    endfunction

endpackage

// File: rtl/sio_ptr_ctl.sv
module sio_ptr_ctl
    import sio_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                ctl_wr,
    input  logic                ctl_rd,
    input  logic [BYTE_W-1:0]   wdata,
    output logic [PTR_W-1:0]    ptr_q,
    output logic [NUM_REGS-1:0] reg_wr,
    output logic                chan_rst,
    output logic                err_rst
);

    cmd_e cmd;
    logic at_zero;
    logic unused_hi;

    assign cmd       = decode_cmd(wdata[CMD_MSB:CMD_LSB]);
    assign at_zero   = (ptr_q == '0);
    assign chan_rst  = ctl_wr && at_zero && (cmd == CMD_CHAN_RST);
    assign err_rst   = ctl_wr && at_zero && (cmd == CMD_ERR_RST);
    assign unused_hi = ^wdata[BYTE_W-1:CMD_MSB+1];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
        assign reg_wr[g] = ctl_wr && (ptr_q == PTR_W'(g));
    end

    always_ff @(posedge clk) begin
        if (rst || chan_rst) begin
            ptr_q <= '0;
        end else if (ctl_wr) begin
            ptr_q <= at_zero ? wdata[PTR_W-1:0] : '0;
        end else if (ctl_rd && !at_zero) begin
            ptr_q <= '0;
        end
    end

endmodule

// File: rtl/sio_wreg_bank.sv
module sio_wreg_bank
    import sio_pkg::*;
#(
    parameter logic [NUM_REGS-1:0] IMPL_MASK = 8'b0011_1010
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             chan_rst,
    input  logic [NUM_REGS-1:0]              reg_wr,
    input  logic [BYTE_W-1:0]                wdata,
    output logic [NUM_REGS-1:0][BYTE_W-1:0]  regs
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        if (IMPL_MASK[g]) begin : g_impl
            always_ff @(posedge clk) begin
                if (rst || chan_rst) begin
                    regs[g] <= '0;
                end else if (reg_wr[g]) begin
                    regs[g] <= wdata;
                end
            end
        end else begin : g_none
            logic unused_wr;
            assign unused_wr = reg_wr[g];
            assign regs[g]   = '0;
        end
    end

endmodule

// File: rtl/sio_rx_status.sv
module sio_rx_status
    import sio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              chan_rst,
    input  logic              err_rst,
    input  logic              rx_en,
    input  logic              rx_strobe,
    input  logic [BYTE_W-1:0] rx_char,
    input  logic              rx_frm_err,
    input  logic              rx_par_err,
    input  logic              data_rd,
    output logic              rx_avail,
    output logic [BYTE_W-1:0] rx_hold,
    output rx_err_t           err_q
);

    logic    take;
    rx_err_t fresh;

    assign take      = rx_strobe && rx_en;
    assign fresh.frm = rx_frm_err;
    assign fresh.par = rx_par_err;
    assign fresh.ovr = rx_avail && !data_rd;

    always_ff @(posedge clk) begin
        if (rst || chan_rst) begin
            rx_avail <= 1'b0;
            rx_hold  <= '0;
            err_q    <= '0;
        end else begin
            if (take) begin
                rx_avail <= 1'b1;
                rx_hold  <= rx_char;
            end else if (data_rd) begin
                rx_avail <= 1'b0;
            end
            err_q <= (err_rst ? rx_err_t'('0) : err_q) | (take ? fresh : rx_err_t'('0));
        end
    end

endmodule

// File: rtl/sio_ctl_port.sv
module sio_ctl_port
    import sio_pkg::*;
#(
    parameter bit                  IS_CHAN_A = 1'b1,
    parameter logic [NUM_REGS-1:0] IMPL_MASK = 8'b0011_1010
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_ctl,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              rx_strobe,
    input  logic [BYTE_W-1:0] rx_char,
    input  logic              rx_frm_err,
    input  logic              rx_par_err,
    input  logic              rx_break,
    input  logic              tx_empty,
    input  logic              cts,
    input  logic              ri,
    input  logic              dcd,
    output logic              rx_enable,
    output logic [1:0]        rx_bits,
    output logic              auto_enable,
    output logic [1:0]        clk_mode,
    output logic [1:0]        stop_sel,
    output logic              parity_en,
    output logic              parity_even,
    output logic              tx_enable,
    output logic [1:0]        tx_bits,
    output logic              send_break,
    output logic              dtr,
    output logic              rts,
    output logic              ext_ie,
    output logic              tx_ie,
    output logic [1:0]        rx_int_mode,
    output logic              tx_load,
    output logic [BYTE_W-1:0] tx_data,
    output int_pend
);

    logic                            ctl_wr, ctl_rd, data_rd, data_wr;
    logic [PTR_W-1:0]                ptr_q;
    logic [NUM_REGS-1:0]             reg_wr;
    logic                            chan_rst, err_rst;
    logic [NUM_REGS-1:0][BYTE_W-1:0] regs;
    logic                            rx_avail;
    logic [BYTE_W-1:0]               rx_hold;
    rx_err_t                         err_q;
    logic [2:0]                      err_vec;
    ie_reg_t                         r_ie;
    rxc_reg_t                        r_rx;
    fmt_reg_t                        r_fmt;
    txc_reg_t                        r_tx;
    line_t                           lines;
    logic                            intp_raw, intp;
    logic                            unused_bits;

    assign ctl_wr  = bus_wr && bus_ctl;
    assign ctl_rd  = bus_rd && bus_ctl && !bus_wr;
    assign data_wr = bus_wr && !bus_ctl;
    assign data_rd = bus_rd && !bus_ctl && !bus_wr;

    sio_ptr_ctl u_ptr (
        .clk      (clk),
        .rst      (rst),
        .ctl_wr   (ctl_wr),
        .ctl_rd   (ctl_rd),
        .wdata    (bus_wdata),
        .ptr_q    (ptr_q),
        .reg_wr   (reg_wr),
        .chan_rst (chan_rst),
        .err_rst  (err_rst)
    );

    sio_wreg_bank #(.IMPL_MASK(IMPL_MASK)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .chan_rst (chan_rst),
        .reg_wr   (reg_wr),
        .wdata    (bus_wdata),
        .regs     (regs)
    );

    assign r_ie  = ie_reg_t'(regs[1]);
    assign r_rx  = rxc_reg_t'(regs[3]);
    assign r_fmt = fmt_reg_t'(regs[4]);
    assign r_tx  = txc_reg_t'(regs[5]);

    sio_rx_status u_rx (
        .clk        (clk),
        .rst        (rst),
        .chan_rst   (chan_rst),
        .err_rst    (err_rst),
        .rx_en      (r_rx.rx_en),
        .rx_strobe  (rx_strobe),
        .rx_char    (rx_char),
        .rx_frm_err (rx_frm_err),
        .rx_par_err (rx_par_err),
        .data_rd    (data_rd),
        .rx_avail   (rx_avail),
        .rx_hold    (rx_hold),
        .err_q      (err_q)
    );

    assign err_vec = err_q;

    // configuration outputs
    assign rx_enable   = r_rx.rx_en;
    assign rx_bits     = r_rx.rx_bits;
    assign auto_enable = r_rx.auto_en;
    assign clk_mode    = r_fmt.clk_mode;
    assign stop_sel    = r_fmt.stop_sel;
    assign parity_en   = r_fmt.par_en;
    assign parity_even = r_fmt.par_even;
    assign tx_enable   = r_tx.tx_en;
    assign tx_bits     = r_tx.tx_bits;
    assign send_break  = r_tx.brk;
    assign dtr         = r_tx.dtr;
    assign rts         = r_tx.rts;
    assign ext_ie      = r_ie.ext_ie;
    assign tx_ie       = r_ie.tx_ie;
    assign rx_int_mode = r_ie.rx_mode;

    // transmit hand-off
    assign tx_load = data_wr && r_tx.tx_en;
    assign tx_data = bus_wdata;

    // interrupt term
    assign lines    = '{brk: rx_break, cts: cts, ri: ri, dcd: dcd, txe: tx_empty};
    assign intp_raw = ((r_ie.rx_mode != 2'b00) && rx_avail)
                    || (r_ie.tx_ie && tx_empty)
                    || (r_ie.ext_ie && rx_break);

    if (IS_CHAN_A) begin : g_int_a
        assign intp = intp_raw;
    end else begin : g_int_b
        logic unused_intp;
        assign unused_intp = intp_raw;
        assign intp        = 1'b0;
    end
    assign int_pend = intp;

    // read path
    always_comb begin
        if (!bus_ctl) begin
            bus_rdata = rx_hold;
        end else begin
            case (ptr_q)
                PTR_W'(0): bus_rdata = build_status(lines, intp, rx_avail);
                PTR_W'(1): bus_rdata = build_err(err_q);
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign unused_bits = ^{r_ie.rsvd_hi, r_ie.rsvd_lo, r_rx.rsvd, r_fmt.rsvd,
                           r_tx.rsvd_hi, r_tx.rsvd_lo, regs[0], regs[2],
                           regs[6], regs[7], reg_wr[0], err_vec};

endmodule

// File: rtl/sio_ctl_port_chk.sv
module sio_ctl_port_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic       bus_ctl,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       rx_strobe,
    input logic       cts,
    input logic       rx_enable,
    input logic       tx_enable,
    input logic       tx_load,
    input logic [2:0] ptr_q,
    input logic       rx_avail,
    input logic [2:0] err_vec,
    input logic       chan_rst
);

    AST_PTR_RETURNS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (ptr_q != 3'd0 && bus_ctl && (bus_wr || bus_rd)) |=> (ptr_q == 3'd0)); // R2

    AST_CHAN_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_ctl && ptr_q == 3'd0 && bus_wdata[5:3] == 3'b011)
        |=> (ptr_q == 3'd0 && !rx_enable && !tx_enable && !rx_avail && err_vec == 3'b000)); // R3

    AST_ERR_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_ctl && ptr_q == 3'd0 && bus_wdata[5:3] == 3'b110 && !rx_strobe)
        |=> (err_vec == 3'b000)); // R4

    AST_STATUS_LAYOUT: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_ctl && !bus_wr && ptr_q == 3'd0)
        |-> (bus_rdata[6] == 1'b0 && bus_rdata[5] == cts && bus_rdata[0] == rx_avail)); // R9

    AST_DATA_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_ctl && !bus_wr && !rx_strobe) |=> !rx_avail); // R10

    AST_STROBE_SETS: assert property (@(posedge clk) disable iff (rst)
        (rx_strobe && rx_enable && !chan_rst) |=> rx_avail); // R10

    AST_LOAD_NEEDS_TX: assert property (@(posedge clk) disable iff (rst)
        tx_load |-> tx_enable); // R12

endmodule

bind sio_ctl_port sio_ctl_port_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_ctl   (bus_ctl),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .rx_strobe (rx_strobe),
    .cts       (cts),
    .rx_enable (rx_enable),
    .tx_enable (tx_enable),
    .tx_load   (tx_load),
    .ptr_q     (ptr_q),
    .rx_avail  (rx_avail),
    .err_vec   (err_vec),
    .chan_rst  (chan_rst)
);

// File: tb/sio_ctl_port_bench.sv
`timescale 1ns/1ps
module sio_ctl_port_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       bus_wr, bus_rd, bus_ctl;
    logic [7:0] bus_wdata, bus_rdata;
    logic       rx_strobe, rx_frm_err, rx_par_err;
    logic [7:0] rx_char;
    logic       rx_break, tx_empty, cts, ri, dcd;
    logic       rx_enable, auto_enable, parity_en, parity_even, tx_enable;
    logic [1:0] rx_bits, clk_mode, stop_sel, tx_bits, rx_int_mode;
    logic       send_break, dtr, rts, ext_ie, tx_ie, tx_load, int_pend;
    logic [7:0] tx_data;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    sio_ctl_port u_sio_ctl_port (.*);

    // reference model state
    logic [7:0] m_wr1, m_wr3, m_wr4, m_wr5, m_hold;
    logic [2:0] m_ptr;
    logic       m_avail, m_frm, m_ovr, m_par;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic exp_intp();
        return ((m_wr1[4:3] != 2'b00) && m_avail) || (m_wr1[1] && tx_empty)
               || (m_wr1[0] && rx_break);
    endfunction

    function automatic logic [7:0] exp_status();
        return {rx_break, 1'b0, cts, ri, dcd, tx_empty, exp_intp(), m_avail};
    endfunction

    function automatic logic [7:0] exp_ctl_read();
        if (m_ptr == 3'd0) return exp_status();
        if (m_ptr == 3'd1) return {1'b0, m_frm, m_ovr, m_par, 4'b0000};
        return 8'h00;
    endfunction

    task automatic model_clear();
        m_wr1 = 0; m_wr3 = 0; m_wr4 = 0; m_wr5 = 0; m_hold = 0;
        m_ptr = 0; m_avail = 0; m_frm = 0; m_ovr = 0; m_par = 0;
    endtask

    task automatic idle();
        bus_wr = 0; bus_rd = 0; bus_ctl = 0; bus_wdata = 0;
        rx_strobe = 0; rx_char = 0; rx_frm_err = 0; rx_par_err = 0;
    endtask

    task automatic finish_cycle();
        @(posedge clk);
        #1;
        idle();
    endtask

    task automatic ctl_write(input logic [7:0] v);
        @(negedge clk);
        bus_wr = 1; bus_ctl = 1; bus_wdata = v;
        finish_cycle();
        if (m_ptr == 3'd0) begin
            if (v[5:3] == 3'b011) begin
                model_clear();
            end else begin
                if (v[5:3] == 3'b110) begin m_frm = 0; m_ovr = 0; m_par = 0; end
                m_ptr = v[2:0];
            end
        end else begin
            case (m_ptr)
                3'd1: m_wr1 = v;
                3'd3: m_wr3 = v;
                3'd4: m_wr4 = v;
                3'd5: m_wr5 = v;
                default: ;
            endcase
            m_ptr = 0;
        end
    endtask

    task automatic ctl_read(input string tag);
        @(negedge clk);
        bus_rd = 1; bus_ctl = 1;
        #1;
        chk(tag, bus_rdata, exp_ctl_read());
        finish_cycle();
        m_ptr = 0;
    endtask

    task automatic data_read(input string tag);
        @(negedge clk);
        bus_rd = 1; bus_ctl = 0;
        #1;
        chk(tag, bus_rdata, m_hold);
        finish_cycle();
        m_avail = 0;
    endtask

    task automatic data_write(input logic [7:0] v, input string tag);
        @(negedge clk);
        bus_wr = 1; bus_ctl = 0; bus_wdata = v;
        #1;
        chk(tag, {tx_load, (tx_load ? tx_data : 8'h00)},
            {m_wr5[3], (m_wr5[3] ? v : 8'h00)});
        finish_cycle();
    endtask

    task automatic deliver(input logic [7:0] ch, input logic f, input logic p);
        @(negedge clk);
        rx_strobe = 1; rx_char = ch; rx_frm_err = f; rx_par_err = p;
        finish_cycle();
        if (m_wr3[0]) begin
            if (m_avail) m_ovr = 1;
            m_frm = m_frm | f;
            m_par = m_par | p;
            m_hold = ch;
            m_avail = 1;
        end
    endtask

    task automatic chk_cfg(input string tag);
        @(negedge clk);
        chk({"R5 ", tag}, {rx_int_mode, tx_ie, ext_ie}, {m_wr1[4:3], m_wr1[1], m_wr1[0]});
        chk({"R6 ", tag}, {rx_bits, auto_enable, rx_enable}, {m_wr3[7:6], m_wr3[5], m_wr3[0]});
        chk({"R7 ", tag}, {clk_mode, stop_sel, parity_even, parity_en},
            {m_wr4[7:6], m_wr4[3:2], m_wr4[1], m_wr4[0]});
        chk({"R8 ", tag}, {dtr, tx_bits, send_break, tx_enable, rts},
            {m_wr5[7], m_wr5[6:5], m_wr5[4], m_wr5[3], m_wr5[1]});
        chk({"R13 ", tag}, int_pend, exp_intp());
    endtask

    initial begin
        #800000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        idle();
        rx_break = 0; tx_empty = 0; cts = 0; ri = 0; dcd = 0;
        model_clear();
        rst = 1;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1: reset state
        @(negedge clk);
        chk("R1 cfg outputs zero",
            {rx_enable, rx_bits, auto_enable, clk_mode, stop_sel, parity_en, parity_even,
             tx_enable, tx_bits, send_break, dtr, rts, ext_ie, tx_ie, rx_int_mode, tx_load, int_pend}, 0);
        ctl_read("R1 status after reset");

        // R3 R5 R6 R7 R8: typical bring-up sequence
        ctl_write(8'h18);
        ctl_write(8'h01); ctl_write(8'h00);
        ctl_write(8'h03); ctl_write(8'hC1);
        ctl_write(8'h04); ctl_write(8'h44);
        ctl_write(8'h05); ctl_write(8'h68);
        ctl_write(8'h00);
        chk_cfg("bring-up");
        chk("R6 8-bit rx enabled", {rx_bits, rx_enable}, 3'b111);
        chk("R7 x16 one stop", {clk_mode, stop_sel, parity_en}, 5'b01010);
        chk("R8 tx 8-bit dtr rts low", {tx_bits, tx_enable, dtr, rts}, 5'b11100);

        // R2: pointer select then auto-return
        ctl_write(8'h03);
        ctl_read("R2 read of register 3 gives 0");
        ctl_read("R2 pointer back to status");
        ctl_write(8'h02); ctl_write(8'hFF);
        chk_cfg("R8 write to register 2 ignored");

        // R9: live lines
        rx_break = 1; cts = 1; dcd = 1;
        ctl_read("R9 live line bits");
        rx_break = 0; cts = 0; dcd = 0; ri = 1; tx_empty = 1;
        ctl_read("R9 ri and tx empty");
        ri = 0; tx_empty = 0;

        // R10: receive path
        deliver(8'h5A, 0, 0);
        ctl_read("R10 available set");
        data_read("R10 data returned");
        ctl_read("R10 available cleared");

        // R11: overrun and error register, R4 error reset
        deliver(8'h11, 1, 0);
        deliver(8'h22, 0, 1);
        ctl_write(8'h01);
        ctl_read("R11 framing overrun parity latched");
        chk("R11 model expects all three", {m_frm, m_ovr, m_par}, 3'b111);
        ctl_write(8'h30);
        ctl_write(8'h01);
        ctl_read("R4 errors cleared");
        chk_cfg("R4 registers kept");
        data_read("R10 last char kept");

        // R10: disabled receiver ignores strobe
        ctl_write(8'h03); ctl_write(8'hC0);
        deliver(8'h77, 1, 1);
        ctl_read("R10 strobe ignored while disabled");
        ctl_write(8'h01);
        ctl_read("R10 no error latched while disabled");

        // R12: transmit load gating
        data_write(8'hA5, "R12 load with tx enabled");
        ctl_write(8'h05); ctl_write(8'h00);
        data_write(8'h3C, "R12 no load with tx disabled");

        // R13: interrupt pending
        tx_empty = 1;
        ctl_write(8'h01); ctl_write(8'h02);
        chk_cfg("R13 tx interrupt");
        ctl_read("R13 status bit 1");
        tx_empty = 0;

        // R3: channel reset with nonzero low bits
        ctl_write(8'h1D);
        chk_cfg("R3 channel reset");
        ctl_read("R3 pointer cleared by reset");

        // random phase
        seed = $urandom(32'h5EED_0C0D);
        for (int i = 0; i < 600; i++) begin
            int op;
            logic [7:0] v;
            op = $urandom_range(0, 6);
            v  = 8'($urandom);
            case (op)
                0: begin
                    if (m_ptr == 3'd0) begin
                        int c;
                        c = $urandom_range(0, 15);
                        v[5:3] = (c == 0) ? 3'b011 : (c < 4) ? 3'b110 : 3'b000;
                        v[7:6] = 2'b00;
                        if (v[5:3] != 3'b011 && $urandom_range(0, 1) == 1)
                            v[2:0] = 3'd3;
                    end
                    ctl_write(v);
                end
                1: ctl_read("R11 random control read");
                2: data_read("R10 random data read");
                3: data_write(v, "R12 random data write");
                4: deliver(v, 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) == 0));
                5: begin
                    {rx_break, cts, ri, dcd, tx_empty} = 5'($urandom);
                    ctl_write(8'h00);
                    ctl_read("R9 random status");
                end
                default: chk_cfg("random");
            endcase
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule